// File: doc/BRIEF.md
# Multicore Boot Release Controller

This controller brings up to three secondary cores out of their parked state once the boot core is already running. A single start pulse hands it a boot entry address, an encoded core count and an errata flag. It then walks a fixed sequence through a small bank of registers. It invalidates the coherence-unit tag RAM, applies an optional diagnostic workaround bit and turns on coherence. For each secondary core in turn it stores the boot address and runs an external power-up sequencer. It finishes by opening the core-enable mask and sending a one-cycle wake event.

The core count input holds the number of cores minus one. A value of zero means a single core, and a start then does nothing. The power-up sequencer is outside this block: the controller raises a one-cycle request naming a core and waits for a done pulse before it moves on. A host port reads any register at any time. It can write a register only while the controller is idle, so that the bench or boot firmware can preset values that the sequence then merges with.

The sequencer states are ST_IDLE, ST_TAG_INV, ST_DIAG_SET, ST_COH_EN, ST_ADDR_LOAD, ST_PWR_REQ, ST_PWR_WAIT, ST_CORE_EN and ST_WAKE, with these transitions:
- ST_IDLE goes to ST_TAG_INV on start with a count field other than zero, and otherwise stays.
- ST_TAG_INV goes to ST_DIAG_SET when the latched errata flag is set, and to ST_COH_EN otherwise.
- ST_DIAG_SET goes to ST_COH_EN.
- ST_COH_EN goes to ST_ADDR_LOAD with the core index set to 1.
- ST_ADDR_LOAD goes to ST_PWR_REQ, and ST_PWR_REQ goes to ST_PWR_WAIT.
- ST_PWR_WAIT stays until done arrives. It then goes to ST_CORE_EN if the core was the last one, and otherwise back to ST_ADDR_LOAD with the index incremented.
- ST_CORE_EN goes to ST_WAKE, and ST_WAKE goes to ST_IDLE.

Register words (host address) are as follows:
- Word 0 is the core-enable mask.
- Words 1 to 3 hold the boot addresses of cores 1 to 3, at byte offset 4*i.
- Word 4 is coherence control, and word 5 is tag invalidate.
- Word 6 is diagnostic control.
- Word 7 reads as zero.

Top module: `boot_release_ctrl`

## Requirements
- R1: After reset busy, wake and power request are low and every register word reads 0.
- R2: The core count is the 2-bit count field plus one; a start with field 0 leaves busy low and changes no register.
- R3: The first action after an accepted start writes 0x0000FFFF to word 5, in the first busy cycle (state ST_TAG_INV).
- R4: When the errata input is high at start, bit 0 of word 6 is set (other bits kept) before coherence is enabled, costing one extra cycle; when low, word 6 is untouched.
- R5: Bit 0 of word 4 is then set, its other bits kept.
- R6: For each secondary core i from 1 to count-1 the boot address is written to word i; words of cores at or above the count keep their value.
- R7: Power requests are one-cycle pulses with the core index on pwr_core_o, issued in ascending order 1, 2, 3. Each follows that core's boot-address write, and none is issued before the previous core's done. A done pulse outside ST_PWR_WAIT has no effect.
- R8: After the last core is powered, word 0 becomes its old value OR bit 0 OR bit i for every secondary core i.
- R9: A wake pulse of exactly one cycle follows the enable write in the next cycle, once per accepted start.
- R10: busy is high from the cycle after an accepted start up to and including the wake cycle; a start while busy is ignored, including its address, count and errata inputs.
- R11: A host write takes effect at the next edge when busy is low and is ignored while busy; reads are combinational and word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| boot_addr_i | input | DW | Boot entry address for the secondary cores |
| core_cfg_i | input | CW | Core count minus one |
| errata_i | input | 1 | Apply the diagnostic workaround bit |
| pwr_start_o | output | 1 | One-cycle power-up request |
| pwr_core_o | output | CW | Core index of the power-up request |
| pwr_done_i | input | 1 | Power-up completion pulse |
| busy_o | output | 1 | Sequence in progress |
| wake_o | output | 1 | One-cycle wake event |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | RA_W | Host register word address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data |

## Verification
The sequence is run with two, three and four cores, with and without the errata flag, and with power-up latencies that differ by core. This separates a wrong loop bound, an extra or missing diagnostic cycle and a controller that does not wait for done. Registers preset through the host port before a run show whether the sequence merges bits or overwrites whole words. The boot word of an absent core is checked to confirm it is left alone. A second start and a host write injected mid-sequence, a count field of zero and a stray done pulse while idle each test that a request which must be ignored really leaves no trace.

// File: rtl/boot_release_pkg.sv
package boot_release_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAG_INV,
        ST_DIAG_SET,
        ST_COH_EN,
        ST_ADDR_LOAD,
        ST_PWR_REQ,
        ST_PWR_WAIT,
        ST_CORE_EN,
        ST_WAKE
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TAG_INV,
        OP_DIAG_SET,
        OP_COH_EN,
        OP_BOOT_ADDR,
        OP_CORE_EN
    } bank_op_e;

endpackage

// File: rtl/boot_core_decode.sv
module boot_core_decode #(
    parameter int NCORE = 4,
    parameter int CW    = $clog2(NCORE)
) (
    input  logic [CW-1:0]    cfg_i,
    output logic             multi_o,
    output logic [CW-1:0]    last_idx_o,
    output logic [NCORE-1:0] mask_o
);
    // Highest core index equals the encoded field (count minus one).
    assign last_idx_o = cfg_i;
    assign multi_o    = (cfg_i != '0);

    // Bit 0 always set; bit j set for each present secondary core.
    assign mask_o[0] = 1'b1;
    for (genvar j = 1; j < NCORE; j++) begin : g_mask
        assign mask_o[j] = (CW'(j) <= cfg_i);
    end
endmodule

// File: rtl/boot_regbank.sv
module boot_regbank
    import boot_release_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NCORE = 4,
    parameter int CW    = $clog2(NCORE),
    parameter int RA_W  = $clog2(NCORE + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_op_e         op_i,
    input  logic [CW-1:0]    op_idx_i,
    input  logic [DW-1:0]    boot_addr_i,
    input  logic [NCORE-1:0] en_mask_i,
    input  logic             host_we_i,
    input  logic [RA_W-1:0]  host_addr_i,
    input  logic [DW-1:0]    host_wdata_i,
    output logic [DW-1:0]    host_rdata_o
);
    localparam int NREG     = NCORE + 3;
    localparam int NSLOT    = 2 ** RA_W;
    localparam int EN_IDX   = 0;
    localparam int CTRL_IDX = NCORE;
    localparam int TAG_IDX  = NCORE + 1;
    localparam int DIAG_IDX = NCORE + 2;
    localparam int TAG_BITS = 4 * NCORE;

    localparam logic [DW-1:0] TAG_ALL = DW'({TAG_BITS{1'b1}});

    logic [DW-1:0]   regs [NSLOT];
    logic [RA_W-1:0] boot_slot;

    assign boot_slot = RA_W'(op_idx_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NSLOT; k++) begin
                regs[k] <= '0;
            end
        end else begin
            unique case (op_i)
                OP_TAG_INV:   regs[TAG_IDX]  <= TAG_ALL;
                OP_DIAG_SET:  regs[DIAG_IDX] <= regs[DIAG_IDX] | DW'(1);
                OP_COH_EN:    regs[CTRL_IDX] <= regs[CTRL_IDX] | DW'(1);
                OP_BOOT_ADDR: regs[boot_slot] <= boot_addr_i;
                OP_CORE_EN:   regs[EN_IDX]   <= regs[EN_IDX] | DW'(en_mask_i);
                default: begin
                    if (host_we_i && (int'(host_addr_i) < NREG)) begin
                        regs[host_addr_i] <= host_wdata_i;
                    end
                end
            endcase
        end
    end

    assign host_rdata_o = (int'(host_addr_i) < NREG) ? regs[host_addr_i] : '0;
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_release_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          multi_i,
    input  logic          errata_i,
    input  logic [CW-1:0] last_idx_i,
    input  logic          pwr_done_i,
    output logic          accept_o,
    output bank_op_e      op_o,
    output logic [CW-1:0] op_idx_o,
    output logic          pwr_start_o,
    output logic [CW-1:0] pwr_core_o,
    output logic          busy_o,
    output logic          wake_o
);
    seq_state_e    state, state_nx;
    logic [CW-1:0] core_idx;
    logic          core_last;

    assign core_last = (core_idx == last_idx_i);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_i && multi_i) state_nx = ST_TAG_INV;
            ST_TAG_INV:   state_nx = errata_i ? ST_DIAG_SET : ST_COH_EN;
            ST_DIAG_SET:  state_nx = ST_COH_EN;
            ST_COH_EN:    state_nx = ST_ADDR_LOAD;
            ST_ADDR_LOAD: state_nx = ST_PWR_REQ;
            ST_PWR_REQ:   state_nx = ST_PWR_WAIT;
            ST_PWR_WAIT:  if (pwr_done_i) state_nx = core_last ? ST_CORE_EN : ST_ADDR_LOAD;
            ST_CORE_EN:   state_nx = ST_WAKE;
            ST_WAKE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register together with the secondary-core index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            core_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_COH_EN) begin
                core_idx <= CW'(1);
            end else if (state == ST_PWR_WAIT && pwr_done_i && !core_last) begin
                core_idx <= core_idx + CW'(1);
            end
        end
    end

    always_comb begin
        op_o        = OP_NONE;
        pwr_start_o = 1'b0;
        wake_o      = 1'b0;
        busy_o      = (state != ST_IDLE);
        accept_o    = 1'b0;
        unique case (state)
            ST_IDLE:      accept_o    = start_i && multi_i;
            ST_TAG_INV:   op_o        = OP_TAG_INV;
            ST_DIAG_SET:  op_o        = OP_DIAG_SET;
            ST_COH_EN:    op_o        = OP_COH_EN;
            ST_ADDR_LOAD: op_o        = OP_BOOT_ADDR;
            ST_PWR_REQ:   pwr_start_o = 1'b1;
            ST_PWR_WAIT:  ;
            ST_CORE_EN:   op_o        = OP_CORE_EN;
            ST_WAKE:      wake_o      = 1'b1;
            default:      ;
        endcase
    end

    assign op_idx_o   = core_idx;
    assign pwr_core_o = core_idx;
endmodule

// File: rtl/boot_release_ctrl.sv
module boot_release_ctrl
    import boot_release_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int DW    = 32,
    parameter int CW    = $clog2(NCORE),
    parameter int RA_W  = $clog2(NCORE + 3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [DW-1:0]   boot_addr_i,
    input  logic [CW-1:0]   core_cfg_i,
    input  logic            errata_i,
    output logic            pwr_start_o,
    output logic [CW-1:0]   pwr_core_o,
    input  logic            pwr_done_i,
    output logic            busy_o,
    output logic            wake_o,
    input  logic            host_we_i,
    input  logic [RA_W-1:0] host_addr_i,
    input  logic [DW-1:0]   host_wdata_i,
    output logic [DW-1:0]   host_rdata_o
);
    logic             multi_live;
    logic [CW-1:0]    last_live;
    logic [NCORE-1:0] mask_live;
    logic             accept;
    bank_op_e         op;
    logic [CW-1:0]    op_idx;

    logic [DW-1:0]    addr_q;
    logic [CW-1:0]    last_q;
    logic [NCORE-1:0] mask_q;
    logic             errata_q;

    boot_core_decode #(.NCORE(NCORE), .CW(CW)) u_decode (
        .cfg_i      (core_cfg_i),
        .multi_o    (multi_live),
        .last_idx_o (last_live),
        .mask_o     (mask_live)
    );

    // Start parameters are frozen at acceptance; later input changes are ignored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            last_q   <= '0;
            mask_q   <= '0;
            errata_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= boot_addr_i;
            last_q   <= last_live;
            mask_q   <= mask_live;
            errata_q <= errata_i;
        end
    end

    boot_seq_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .multi_i     (multi_live),
        .errata_i    (errata_q),
        .last_idx_i  (last_q),
        .pwr_done_i  (pwr_done_i),
        .accept_o    (accept),
        .op_o        (op),
        .op_idx_o    (op_idx),
        .pwr_start_o (pwr_start_o),
        .pwr_core_o  (pwr_core_o),
        .busy_o      (busy_o),
        .wake_o      (wake_o)
    );

    boot_regbank #(.DW(DW), .NCORE(NCORE), .CW(CW), .RA_W(RA_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .op_idx_i     (op_idx),
        .boot_addr_i  (addr_q),
        .en_mask_i    (mask_q),
        .host_we_i    (host_we_i && !busy_o),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o)
    );
endmodule

// File: rtl/boot_release_chk.sv
module boot_release_chk #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [CW-1:0] core_cfg_i,
    input logic          pwr_start_o,
    input logic [CW-1:0] pwr_core_o,
    input logic          pwr_done_i,
    input logic          busy_o,
    input logic          wake_o
);
    logic          pend;
    logic [CW-1:0] prev_core;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            prev_core <= '0;
        end else begin
            if (pwr_start_o) begin
                pend      <= 1'b1;
                prev_core <= pwr_core_o;
            end else if (pwr_done_i) begin
                pend <= 1'b0;
            end
            if (wake_o) prev_core <= '0;
        end
    end

    // R2
    single_core_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_cfg_i == '0) |=> !busy_o);

    // R10
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && core_cfg_i != '0) |=> busy_o);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wake_o) |=> busy_o);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(wake_o));

    // R9
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R9
    wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> busy_o);

    // R7
    pwr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_start_o |=> !pwr_start_o);

    // R7
    pwr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_start_o |-> !pend);

    // R7
    pwr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_start_o |-> (pwr_core_o == prev_core + CW'(1)) && busy_o);
endmodule

bind boot_release_ctrl boot_release_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .core_cfg_i  (core_cfg_i),
    .pwr_start_o (pwr_start_o),
    .pwr_core_o  (pwr_core_o),
    .pwr_done_i  (pwr_done_i),
    .busy_o      (busy_o),
    .wake_o      (wake_o)
);

// File: tb/boot_release_ctrl_bench.sv
module boot_release_ctrl_bench;
    typedef struct packed {
        logic       busy;
        logic       ps;
        logic [1:0] core;
        logic       wake;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] boot_addr = '0;
    logic [1:0]  core_cfg = '0;
    logic        errata_in = 1'b0;
    logic        pwr_start;
    logic [1:0]  pwr_core;
    logic        stub_done = 1'b0;
    logic        spur_done = 1'b0;
    logic        pwr_done;
    logic        busy;
    logic        wake;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    int stub_cnt = 0;
    int lat_base = 1;
    exp_t q[$];
    logic [31:0] exp_reg [8];

    assign pwr_done = stub_done | spur_done;

    always #2 clk = ~clk;

    boot_release_ctrl u_boot_release_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .boot_addr_i(boot_addr),
        .core_cfg_i(core_cfg), .errata_i(errata_in), .pwr_start_o(pwr_start),
        .pwr_core_o(pwr_core), .pwr_done_i(pwr_done), .busy_o(busy), .wake_o(wake),
        .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
        .host_rdata_o(host_rdata)
    );

    // Power-up sequencer stub: done arrives lat_base+core cycles after request.
    always @(negedge clk) begin
        if (stub_done) stub_done = 1'b0;
        if (stub_cnt > 0) begin
            stub_cnt = stub_cnt - 1;
            if (stub_cnt == 0) stub_done = 1'b1;
        end
        if (pwr_start) stub_cnt = lat_base + int'(pwr_core);
    end

    // Cycle-by-cycle comparison against the expected trace.
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            exp_t e;
            e = (q.size() > 0) ? q.pop_front() : exp_t'(0);
            checks++;
            if (busy !== e.busy) begin
                errors++;
                $display("FAIL R10 busy: got %0b expected %0b at %0t", busy, e.busy, $time);
            end
            if (wake !== e.wake) begin
                errors++;
                $display("FAIL R9 wake: got %0b expected %0b at %0t", wake, e.wake, $time);
            end
            if (pwr_start !== e.ps || (e.ps && pwr_core !== e.core)) begin
                errors++;
                $display("FAIL R7 power request: got %0b/core %0d expected %0b/core %0d at %0t",
                         pwr_start, pwr_core, e.ps, e.core, $time);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: busy=%0b expected sequence completion", busy);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic push(input logic b, input logic ps, input int core, input logic w);
        exp_t e;
        e.busy = b; e.ps = ps; e.core = core[1:0]; e.wake = w;
        q.push_back(e);
    endtask

    task automatic chk_reg(input int addr, input string req);
        @(negedge clk);
        host_addr = addr[2:0];
        #1;
        checks++;
        if (host_rdata !== exp_reg[addr]) begin
            errors++;
            $display("FAIL %s word %0d: got %h expected %h", req, addr, host_rdata, exp_reg[addr]);
        end
    endtask

    task automatic host_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        host_we = 1'b1; host_addr = addr[2:0]; host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
        exp_reg[addr] = data;
    endtask

    task automatic run_boot(input int cfg, input logic [31:0] addr, input bit errata,
                            input int lat, input bit poke);
        lat_base = lat;
        @(negedge clk);
        start = 1'b1; core_cfg = cfg[1:0]; boot_addr = addr; errata_in = errata;
        @(negedge clk);
        start = 1'b0;
        if (cfg > 0) begin
            push(1, 0, 0, 0);                    // tag invalidate
            if (errata) push(1, 0, 0, 0);        // diagnostic bit
            push(1, 0, 0, 0);                    // coherence enable
            for (int i = 1; i <= cfg; i++) begin
                push(1, 0, 0, 0);                // boot address load
                push(1, 1, i, 0);                // power request
                for (int k = 0; k < lat + i; k++) push(1, 0, 0, 0);
            end
            push(1, 0, 0, 0);                    // enable mask
            push(1, 0, 0, 1);                    // wake
            exp_reg[5] = 32'h0000_FFFF;
            if (errata) exp_reg[6] = exp_reg[6] | 32'h1;
            exp_reg[4] = exp_reg[4] | 32'h1;
            for (int i = 1; i <= cfg; i++) exp_reg[i] = addr;
            exp_reg[0] = exp_reg[0] | ((32'd2 << cfg) - 32'd1);
        end
        if (poke) begin
            // R10 / R11: a second start and a host write while busy must be ignored.
            @(negedge clk);
            start = 1'b1; core_cfg = 2'd3; boot_addr = 32'hFFFF_0000; errata_in = 1'b0;
            host_we = 1'b1; host_addr = 3'd0; host_wdata = 32'h8000_0000;
            @(negedge clk);
            start = 1'b0; host_we = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) exp_reg[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word
        for (int k = 0; k < 8; k++) chk_reg(k, "R1");

        // R2: count field 0 means one core, start has no effect
        run_boot(0, 32'h1234_5678, 1'b1, 1, 1'b0);
        for (int k = 0; k < 8; k++) chk_reg(k, "R2");

        // R11: idle host writes preset words
        host_write(0, 32'h0000_0100);
        host_write(4, 32'h0000_0010);
        host_write(6, 32'h0000_0020);
        host_write(3, 32'hDEAD_0003);
        chk_reg(0, "R11"); chk_reg(4, "R11"); chk_reg(6, "R11"); chk_reg(3, "R11");

        // Two cores, no errata
        run_boot(1, 32'h1000_0040, 1'b0, 1, 1'b0);
        chk_reg(5, "R3");
        chk_reg(6, "R4");
        chk_reg(4, "R5");
        chk_reg(1, "R6"); chk_reg(2, "R6"); chk_reg(3, "R6");
        chk_reg(0, "R8");

        // Four cores, errata, mid-sequence start and host write ignored
        run_boot(3, 32'h8000_1000, 1'b1, 3, 1'b1);
        chk_reg(6, "R4");
        chk_reg(4, "R5");
        chk_reg(1, "R6"); chk_reg(2, "R6"); chk_reg(3, "R6");
        chk_reg(0, "R8");
        chk_reg(0, "R11");

        // Three cores: word 3 keeps the previous run's address
        run_boot(2, 32'h0000_2222, 1'b0, 0, 1'b0);
        chk_reg(1, "R6"); chk_reg(2, "R6"); chk_reg(3, "R6");
        chk_reg(0, "R8");
        chk_reg(5, "R3");

        // R7: stray done while idle starts nothing
        @(negedge clk); spur_done = 1'b1;
        @(negedge clk); spur_done = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (busy !== 1'b0 || pwr_start !== 1'b0) begin
            errors++;
            $display("FAIL R7 stray done: busy=%0b pwr_start=%0b expected 0/0", busy, pwr_start);
        end

        // R11: unmapped word reads zero
        chk_reg(7, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule